// File: doc/BRIEF.md
# Deferred Masked Write-Back Register File

This block holds the architectural register state of a small processor core: sixteen 16-bit general registers and two 40-bit accumulators. Execution units do not write that state directly. Each result is posted into a pending queue as a destination, a data value and a keep-mask. Nothing architectural changes until the packet ends with a flush. Any read made while the packet is still running returns the state from before the packet.

A flush applies every pending entry in the order it was posted. Each destination becomes its old value ANDed with the keep-mask, ORed with the new data. The updated state is visible on the cycle after the flush. A discard throws the pending entries away and changes nothing.

Register 15 is the stack pointer and is always visible on its own output. A 32-bit register pair can be read in one access. A 32-bit pair can be posted in one request, which takes two queue slots.

Top module: `deferred_wb_rf`

## Requirements
- R1: A posted write is not visible on any read output until a flush commits it. Reads always return committed state.
- R2: On flush, a general-register entry sets the register to (old AND keep[15:0]) OR data[15:0]. A keep of zero replaces the register completely.
- R3: The queue holds at most 16 entries. `post_drop` is high in the same cycle as a post that needs more slots than are free. A dropped post leaves the queue and the state unchanged.
- R4: A flush applies the entries in posting order, so a later entry to the same destination sees the result of the earlier ones. After the flush, `pend_count` is 0.
- R5: A discard empties the queue and changes no register. It has priority over a flush and over a post in the same cycle.
- R6: A post accepted in the same cycle as a flush is committed by that flush, after all the entries queued before it.
- R7: An accumulator post (`post_acc`=1, `post_pair`=0) selects the accumulator with `post_idx[0]`. The commit keeps only data bits [39:0] and applies the 40-bit keep-mask. Data bits [47:40] are ignored.
- R8: `prd_data` returns register N in bits [31:16] and register (N+1) mod 16 in bits [15:0], where N is `prd_idx`.
- R9: A pair post (`post_pair`=1) queues two full-replace entries: data[31:16] to register N and data[15:0] to register (N+1) mod 16. It needs two free slots; otherwise both halves are dropped.
- R10: `sp_data` always shows committed register 15.
- R11: While `rst_n` is low at a clock edge, all registers, both accumulators and the pending count are cleared.
- R12: `pend_count` rises by one for each accepted single post and by two for each accepted pair post, provided no flush or discard happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_en | input | 1 | Post request this cycle |
| post_acc | input | 1 | Destination is an accumulator |
| post_pair | input | 1 | Post a 32-bit register pair |
| post_idx | input | 4 | Destination register, or accumulator in bit 0 |
| post_data | input | 48 | New data |
| post_keep | input | 40 | Keep-mask of old bits |
| flush | input | 1 | Commit all pending entries |
| discard | input | 1 | Drop all pending entries |
| post_drop | output | 1 | Current post rejected for lack of room |
| pend_count | output | 5 | Entries pending |
| rd_idx | input | 4 | Single register read index |
| rd_data | output | 16 | Committed register value |
| prd_idx | input | 4 | Pair read base index |
| prd_data | output | 32 | Committed register pair |
| acc_sel | input | 1 | Accumulator read select |
| acc_data | output | 40 | Committed accumulator value |
| sp_data | output | 16 | Committed stack pointer (register 15) |

## Verification
The bench targets these corner cases:
- Several writes to the same register inside one packet. A design that ignores posting order leaves an earlier value in place.
- A post in the same cycle as a flush. A design that loses or reorders this post leaves a stale value.
- A flush and a discard in the same cycle. A design that gives the flush priority modifies registers it should leave alone.
- A full queue, and a pair post that finds only one free slot. A design with an off-by-one in the room check accepts a write it must drop, or commits half a pair.
- A pair post at register 15, which must wrap to register 0.
- Accumulator data with bits set above bit 39, which a design that fails to truncate would let through.

// File: rtl/wbq_pkg.sv
// Package: shared constants for the deferred write-back register file.
// Assumes the register count is a power of two so index arithmetic wraps.
package wbq_pkg;
    localparam int WBQ_NREG  = 16;   // general registers
    localparam int WBQ_RW    = 16;   // general register width
    localparam int WBQ_AW    = 40;   // accumulator width
    localparam int WBQ_IW    = 48;   // posted data width
    localparam int WBQ_DEPTH = 16;   // pending entries
    localparam int WBQ_NACC  = 2;    // accumulators

    // Destination class of one pending entry
    typedef enum logic {
        DST_GPR = 1'b0,
        DST_ACC = 1'b1
    } wbq_dst_e;
endpackage

// File: rtl/wbq_queue.sv
// Module: wbq_queue
// Pending-entry store. Holds up to DEPTH entries in posting order and can
// append one or two entries per cycle. The caller guarantees room before
// pushing. A clear empties the store; entry contents are then don't-care.
module wbq_queue
    import wbq_pkg::*;
#(
    parameter int DEPTH = WBQ_DEPTH,
    parameter int IDXW  = 4,
    parameter int AW    = WBQ_AW,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            push0,
    input  logic            push1,
    input  wbq_dst_e        e0_dst,
    input  logic [IDXW-1:0] e0_idx,
    input  logic [AW-1:0]   e0_data,
    input  logic [AW-1:0]   e0_keep,
    input  wbq_dst_e        e1_dst,
    input  logic [IDXW-1:0] e1_idx,
    input  logic [AW-1:0]   e1_data,
    input  logic [AW-1:0]   e1_keep,
    output wbq_dst_e        q_dst  [DEPTH],
    output logic [IDXW-1:0] q_idx  [DEPTH],
    output logic [AW-1:0]   q_data [DEPTH],
    output logic [AW-1:0]   q_keep [DEPTH],
    output logic [CW-1:0]   count
);
    logic [CW-1:0] slot1;
    assign slot1 = count + CW'(1);

    // Occupancy counter: cleared on reset or clear, else grows by the pushes
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else                 count <= count + CW'(push0) + CW'(push1);
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Slot s captures the first push at the tail, or the second one after it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_dst[s]  <= DST_GPR;
                q_idx[s]  <= '0;
                q_data[s] <= '0;
                q_keep[s] <= '0;
            end else if (push0 && count == CW'(s)) begin
                q_dst[s]  <= e0_dst;
                q_idx[s]  <= e0_idx;
                q_data[s] <= e0_data;
                q_keep[s] <= e0_keep;
            end else if (push1 && slot1 == CW'(s)) begin
                q_dst[s]  <= e1_dst;
                q_idx[s]  <= e1_idx;
                q_data[s] <= e1_data;
                q_keep[s] <= e1_keep;
            end
        end
    end
endmodule

// File: rtl/wbq_commit.sv
// Module: wbq_commit
// Combinational merge network. Starting from the committed state, it
// applies the valid queued entries in order, then up to two entries posted
// in the flush cycle itself. Each step is (old & keep) | data.
// Accumulator entries select an accumulator with index bit 0.
module wbq_commit
    import wbq_pkg::*;
#(
    parameter int DEPTH = WBQ_DEPTH,
    parameter int NREG  = WBQ_NREG,
    parameter int NACC  = WBQ_NACC,
    parameter int RW    = WBQ_RW,
    parameter int AW    = WBQ_AW,
    parameter int IDXW  = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [RW-1:0]   cur_gpr [NREG],
    input  logic [AW-1:0]   cur_acc [NACC],
    input  wbq_dst_e        q_dst   [DEPTH],
    input  logic [IDXW-1:0] q_idx   [DEPTH],
    input  logic [AW-1:0]   q_data  [DEPTH],
    input  logic [AW-1:0]   q_keep  [DEPTH],
    input  logic [CW-1:0]   count,
    input  logic            in0_en,
    input  wbq_dst_e        in0_dst,
    input  logic [IDXW-1:0] in0_idx,
    input  logic [AW-1:0]   in0_data,
    input  logic [AW-1:0]   in0_keep,
    input  logic            in1_en,
    input  wbq_dst_e        in1_dst,
    input  logic [IDXW-1:0] in1_idx,
    input  logic [AW-1:0]   in1_data,
    input  logic [AW-1:0]   in1_keep,
    output logic [RW-1:0]   nxt_gpr [NREG],
    output logic [AW-1:0]   nxt_acc [NACC]
);
    localparam int TOT  = DEPTH + 2;
    localparam int ASEL = (NACC > 1) ? $clog2(NACC) : 1;

    logic            l_en   [TOT];
    wbq_dst_e        l_dst  [TOT];
    logic [IDXW-1:0] l_idx  [TOT];
    logic [AW-1:0]   l_data [TOT];
    logic [AW-1:0]   l_keep [TOT];

    // Lay queued entries and same-cycle posts out as one ordered list
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            l_en[i]   = (CW'(i) < count);
            l_dst[i]  = q_dst[i];
            l_idx[i]  = q_idx[i];
            l_data[i] = q_data[i];
            l_keep[i] = q_keep[i];
        end
        l_en[DEPTH]     = in0_en;
        l_dst[DEPTH]    = in0_dst;
        l_idx[DEPTH]    = in0_idx;
        l_data[DEPTH]   = in0_data;
        l_keep[DEPTH]   = in0_keep;
        l_en[DEPTH+1]   = in1_en;
        l_dst[DEPTH+1]  = in1_dst;
        l_idx[DEPTH+1]  = in1_idx;
        l_data[DEPTH+1] = in1_data;
        l_keep[DEPTH+1] = in1_keep;
    end

    // Walk the list in order, merging each valid entry into its destination
    always_comb begin
        nxt_gpr = cur_gpr;
        nxt_acc = cur_acc;
        for (int i = 0; i < TOT; i++) begin
            if (l_en[i]) begin
                if (l_dst[i] == DST_ACC)
                    nxt_acc[l_idx[i][ASEL-1:0]] =
                        (nxt_acc[l_idx[i][ASEL-1:0]] & l_keep[i]) | l_data[i];
                else
                    nxt_gpr[l_idx[i]] =
                        (nxt_gpr[l_idx[i]] & l_keep[i][RW-1:0]) | l_data[i][RW-1:0];
            end
        end
    end
endmodule

// File: rtl/wbq_state.sv
// Module: wbq_state
// Architectural state registers: general registers and accumulators.
// Loads the merged next state when told to commit and clears on reset.
module wbq_state
    import wbq_pkg::*;
#(
    parameter int NREG = WBQ_NREG,
    parameter int NACC = WBQ_NACC,
    parameter int RW   = WBQ_RW,
    parameter int AW   = WBQ_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [RW-1:0] nxt_gpr [NREG],
    input  logic [AW-1:0] nxt_acc [NACC],
    output logic [RW-1:0] gpr     [NREG],
    output logic [AW-1:0] acc     [NACC]
);
    // Committed state update: clear on reset, take merged values on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) gpr[r] <= '0;
            for (int a = 0; a < NACC; a++) acc[a] <= '0;
        end else if (load) begin
            gpr <= nxt_gpr;
            acc <= nxt_acc;
        end
    end
endmodule

// File: rtl/deferred_wb_rf.sv
// Module: deferred_wb_rf (top)
// Register file with a deferred, masked write-back queue. Posts are held
// until flush, then committed in order as (old & keep) | data. Discard
// wins over flush and post. Reads see only committed state.
// Assumes NREG is a power of two and IW >= 2*RW, AW >= RW.
module deferred_wb_rf
    import wbq_pkg::*;
#(
    parameter int NREG   = WBQ_NREG,
    parameter int RW     = WBQ_RW,
    parameter int AW     = WBQ_AW,
    parameter int IW     = WBQ_IW,
    parameter int DEPTH  = WBQ_DEPTH,
    parameter int SP_IDX = 15,
    parameter int IDXW   = $clog2(NREG),
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            post_en,
    input  logic            post_acc,
    input  logic            post_pair,
    input  logic [IDXW-1:0] post_idx,
    input  logic [IW-1:0]   post_data,
    input  logic [AW-1:0]   post_keep,
    input  logic            flush,
    input  logic            discard,
    output logic            post_drop,
    output logic [CW-1:0]   pend_count,
    input  logic [IDXW-1:0] rd_idx,
    output logic [RW-1:0]   rd_data,
    input  logic [IDXW-1:0] prd_idx,
    output logic [2*RW-1:0] prd_data,
    input  logic            acc_sel,
    output logic [AW-1:0]   acc_data,
    output logic [RW-1:0]   sp_data
);
    localparam int NACC = WBQ_NACC;

    logic [CW-1:0]   need, room;
    logic            accept, push0, push1, in0_en, in1_en, load;
    wbq_dst_e        e0_dst, e1_dst;
    logic [IDXW-1:0] e0_idx, e1_idx, prd_nxt;
    logic [AW-1:0]   e0_data, e0_keep, e1_data, e1_keep;

    wbq_dst_e        q_dst  [DEPTH];
    logic [IDXW-1:0] q_idx  [DEPTH];
    logic [AW-1:0]   q_data [DEPTH];
    logic [AW-1:0]   q_keep [DEPTH];
    logic [RW-1:0]   gpr     [NREG];
    logic [RW-1:0]   nxt_gpr [NREG];
    logic [AW-1:0]   acc     [NACC];
    logic [AW-1:0]   nxt_acc [NACC];

    // Room check and the control decode for push, commit and clear
    always_comb begin
        need      = post_pair ? CW'(2) : CW'(1);
        room      = CW'(DEPTH) - pend_count;
        post_drop = post_en && (need > room);
        accept    = post_en && !post_drop && !discard;
        push0     = accept && !flush;
        push1     = push0 && post_pair;
        in0_en    = accept && flush;
        in1_en    = in0_en && post_pair;
        load      = flush && !discard;
    end

    // Shape the posted request into one or two queue entries
    always_comb begin
        e1_dst  = DST_GPR;
        e1_idx  = post_idx + IDXW'(1);
        e1_data = {{(AW-RW){1'b0}}, post_data[RW-1:0]};
        e1_keep = '0;
        if (post_pair) begin
            e0_dst  = DST_GPR;
            e0_idx  = post_idx;
            e0_data = {{(AW-RW){1'b0}}, post_data[2*RW-1:RW]};
            e0_keep = '0;
        end else if (post_acc) begin
            e0_dst  = DST_ACC;
            e0_idx  = post_idx;
            e0_data = post_data[AW-1:0];
            e0_keep = post_keep;
        end else begin
            e0_dst  = DST_GPR;
            e0_idx  = post_idx;
            e0_data = {{(AW-RW){1'b0}}, post_data[RW-1:0]};
            e0_keep = {{(AW-RW){1'b0}}, post_keep[RW-1:0]};
        end
    end

    wbq_queue #(.DEPTH(DEPTH), .IDXW(IDXW), .AW(AW), .CW(CW)) i_queue (
        .clk(clk), .rst_n(rst_n), .clear(flush || discard),
        .push0(push0), .push1(push1),
        .e0_dst(e0_dst), .e0_idx(e0_idx), .e0_data(e0_data), .e0_keep(e0_keep),
        .e1_dst(e1_dst), .e1_idx(e1_idx), .e1_data(e1_data), .e1_keep(e1_keep),
        .q_dst(q_dst), .q_idx(q_idx), .q_data(q_data), .q_keep(q_keep),
        .count(pend_count)
    );

    wbq_commit #(.DEPTH(DEPTH), .NREG(NREG), .NACC(NACC), .RW(RW), .AW(AW),
                 .IDXW(IDXW), .CW(CW)) i_commit (
        .cur_gpr(gpr), .cur_acc(acc),
        .q_dst(q_dst), .q_idx(q_idx), .q_data(q_data), .q_keep(q_keep),
        .count(pend_count),
        .in0_en(in0_en), .in0_dst(e0_dst), .in0_idx(e0_idx),
        .in0_data(e0_data), .in0_keep(e0_keep),
        .in1_en(in1_en), .in1_dst(e1_dst), .in1_idx(e1_idx),
        .in1_data(e1_data), .in1_keep(e1_keep),
        .nxt_gpr(nxt_gpr), .nxt_acc(nxt_acc)
    );

    wbq_state #(.NREG(NREG), .NACC(NACC), .RW(RW), .AW(AW)) i_state (
        .clk(clk), .rst_n(rst_n), .load(load),
        .nxt_gpr(nxt_gpr), .nxt_acc(nxt_acc),
        .gpr(gpr), .acc(acc)
    );

    // Read ports: committed state only, pair read wraps at the top index
    always_comb begin
        prd_nxt  = prd_idx + IDXW'(1);
        rd_data  = gpr[rd_idx];
        prd_data = {gpr[prd_idx], gpr[prd_nxt]};
        acc_data = acc[acc_sel];
        sp_data  = gpr[SP_IDX];
    end
endmodule

// File: rtl/deferred_wb_rf_chk.sv
// Module: deferred_wb_rf_chk
// Temporal checks on the pending count and the committed stack pointer,
// attached to every deferred_wb_rf instance by the bind below.
module deferred_wb_rf_chk #(
    parameter int DEPTH = 16,
    parameter int RW    = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          post_en,
    input logic          post_pair,
    input logic          flush,
    input logic          discard,
    input logic          post_drop,
    input logic [CW-1:0] pend_count,
    input logic [RW-1:0] sp_data
);
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_count <= CW'(DEPTH));

    assert_drop_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (post_drop && !flush && !discard) |=> pend_count == $past(pend_count));

    assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> pend_count == '0);

    assert_discard_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> pend_count == '0);

    assert_discard_keeps_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> $stable(sp_data));

    assert_no_commit_without_flush_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> $stable(sp_data));

    assert_count_grows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (post_en && !post_drop && !flush && !discard)
        |=> pend_count == $past(pend_count) + (($past(post_pair)) ? CW'(2) : CW'(1)));

    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> (pend_count == '0 && sp_data == '0));
endmodule

bind deferred_wb_rf deferred_wb_rf_chk #(.DEPTH(DEPTH), .RW(RW), .CW(CW)) i_chk (
    .clk(clk), .rst_n(rst_n), .post_en(post_en), .post_pair(post_pair),
    .flush(flush), .discard(discard), .post_drop(post_drop),
    .pend_count(pend_count), .sp_data(sp_data)
);

// File: tb/test_deferred_wb_rf.sv
`timescale 1ns/1ps
// Bench for deferred_wb_rf: directed corner cases followed by seeded random
// traffic, all compared against a reference model kept in the bench.
module test_deferred_wb_rf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_en = 1'b0, post_acc = 1'b0, post_pair = 1'b0;
    logic [3:0]  post_idx = '0;
    logic [47:0] post_data = '0;
    logic [39:0] post_keep = '0;
    logic        flush = 1'b0, discard = 1'b0;
    logic        post_drop;
    logic [4:0]  pend_count;
    logic [3:0]  rd_idx = '0, prd_idx = '0;
    logic [15:0] rd_data, sp_data;
    logic [31:0] prd_data;
    logic        acc_sel = 1'b0;
    logic [39:0] acc_data;

    int nchk = 0, nfail = 0;
    bit done = 0;

    // reference model state
    bit [15:0] mg [16];
    bit [39:0] ma [2];
    bit        qa [18];
    bit [3:0]  qi [18];
    bit [39:0] qd [18], qm [18];
    int        mcnt = 0;

    always #2 clk = ~clk;

    deferred_wb_rf i_deferred_wb_rf (
        .clk(clk), .rst_n(rst_n), .post_en(post_en), .post_acc(post_acc),
        .post_pair(post_pair), .post_idx(post_idx), .post_data(post_data),
        .post_keep(post_keep), .flush(flush), .discard(discard),
        .post_drop(post_drop), .pend_count(pend_count),
        .rd_idx(rd_idx), .rd_data(rd_data), .prd_idx(prd_idx), .prd_data(prd_data),
        .acc_sel(acc_sel), .acc_data(acc_data), .sp_data(sp_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int r = 0; r < 16; r++) mg[r] = '0;
        ma[0] = '0; ma[1] = '0; mcnt = 0;
    endfunction

    function automatic void model_push(bit a, bit [3:0] i, bit [39:0] d, bit [39:0] m);
        qa[mcnt] = a; qi[mcnt] = i; qd[mcnt] = d; qm[mcnt] = m; mcnt++;
    endfunction

    function automatic void model_commit();
        for (int e = 0; e < mcnt; e++) begin
            if (qa[e]) ma[qi[e][0]] = (ma[qi[e][0]] & qm[e]) | qd[e];
            else       mg[qi[e]]    = (mg[qi[e]] & qm[e][15:0]) | qd[e][15:0];
        end
        mcnt = 0;
    endfunction

    // One cycle of stimulus; checks all outputs against the model, then advances it
    task automatic step(input bit en, input bit a, input bit pr, input bit [3:0] idx,
                        input bit [47:0] d, input bit [39:0] k, input bit fl, input bit dc);
        bit drop;
        bit [3:0] pn;
        @(negedge clk);
        post_en = en; post_acc = a; post_pair = pr; post_idx = idx;
        post_data = d; post_keep = k; flush = fl; discard = dc;
        rd_idx = 4'($urandom); prd_idx = 4'($urandom); acc_sel = 1'($urandom);
        #1;
        pn = prd_idx + 4'd1;
        drop = en && ((pr ? 2 : 1) > 16 - mcnt);
        chk("R1 rd_data", 64'(rd_data), 64'(mg[rd_idx]));
        chk("R8 prd_data", 64'(prd_data), 64'({mg[prd_idx], mg[pn]}));
        chk("R7 acc_data", 64'(acc_data), 64'(ma[acc_sel]));
        chk("R10 sp_data", 64'(sp_data), 64'(mg[15]));
        chk("R12 pend_count", 64'(pend_count), 64'(mcnt));
        chk("R3 post_drop", 64'(post_drop), 64'(drop));
        if (dc) mcnt = 0;
        else begin
            if (en && !drop) begin
                if (pr) begin
                    model_push(1'b0, idx, 40'(d[31:16]), '0);
                    model_push(1'b0, idx + 4'd1, 40'(d[15:0]), '0);
                end else if (a) model_push(1'b1, idx, d[39:0], k);
                else            model_push(1'b0, idx, 40'(d[15:0]), 40'(k[15:0]));
            end
            if (fl) model_commit();
        end
    endtask

    task automatic idle_in();
        post_en = 0; post_acc = 0; post_pair = 0; flush = 0; discard = 0;
    endtask

    task automatic expect_reg(input bit [3:0] i, input bit [15:0] exp, input string tag);
        @(negedge clk); idle_in(); rd_idx = i; #1;
        chk(tag, 64'(rd_data), 64'(exp));
    endtask

    task automatic expect_acc(input bit s, input bit [39:0] exp, input string tag);
        @(negedge clk); idle_in(); acc_sel = s; #1;
        chk(tag, 64'(acc_data), 64'(exp));
    endtask

    task automatic expect_pair(input bit [3:0] i, input bit [31:0] exp, input string tag);
        @(negedge clk); idle_in(); prd_idx = i; #1;
        chk(tag, 64'(prd_data), 64'(exp));
    endtask

    task automatic expect_cnt(input int exp, input string tag);
        @(negedge clk); idle_in(); #1;
        chk(tag, 64'(pend_count), 64'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk); idle_in(); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; model_clear();
    endtask

    // Watchdog: a hung run counts as one failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        do_reset();
        // R11: state cleared by reset
        for (int r = 0; r < 16; r++) expect_reg(4'(r), 16'h0, "R11 reset reg");
        expect_acc(1'b0, 40'h0, "R11 reset acc0");
        expect_acc(1'b1, 40'h0, "R11 reset acc1");
        expect_cnt(0, "R11 reset count");

        // R1 / R2: invisible until flush, then full replace
        step(1, 0, 0, 4'd3, 48'h1234, 40'h0, 0, 0);
        expect_reg(4'd3, 16'h0000, "R1 before flush");
        step(0, 0, 0, 0, 0, 0, 1, 0);
        expect_reg(4'd3, 16'h1234, "R2 full replace");
        // R2: masked merge
        step(1, 0, 0, 4'd3, 48'hAB00, 40'h00FF, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        expect_reg(4'd3, 16'hAB34, "R2 masked merge");

        // R4: ordering on one destination
        step(1, 0, 0, 4'd5, 48'h1111, 40'h0, 0, 0);
        step(1, 0, 0, 4'd5, 48'h2222, 40'h0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        expect_reg(4'd5, 16'h2222, "R4 posting order");
        expect_cnt(0, "R4 count after flush");

        // R6: post in the flush cycle lands last
        step(1, 0, 0, 4'd6, 48'h0A0A, 40'h0, 0, 0);
        step(1, 0, 0, 4'd6, 48'h0B0B, 40'h0, 1, 0);
        expect_reg(4'd6, 16'h0B0B, "R6 same-cycle post");

        // R5: discard, and discard beating flush and post
        step(1, 0, 0, 4'd7, 48'h7777, 40'h0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        expect_reg(4'd7, 16'h0000, "R5 discard");
        step(1, 0, 0, 4'd7, 48'h5555, 40'h0, 0, 0);
        step(1, 0, 0, 4'd7, 48'h6666, 40'h0, 1, 1);
        expect_reg(4'd7, 16'h0000, "R5 discard over flush");
        expect_cnt(0, "R5 count after discard");

        // R3: full queue drops the seventeenth post
        for (int i = 0; i < 16; i++) step(1, 0, 0, 4'd8, 48'(i + 1), 40'h0, 0, 0);
        expect_cnt(16, "R3 full count");
        step(1, 0, 0, 4'd8, 48'h00FF, 40'h0, 0, 0);
        expect_cnt(16, "R3 count after drop");
        step(0, 0, 0, 0, 0, 0, 1, 0);
        expect_reg(4'd8, 16'h0010, "R3 dropped write absent");

        // R9: pair needs two slots
        for (int i = 0; i < 15; i++) step(1, 0, 0, 4'd9, 48'(i), 40'h0, 0, 0);
        step(1, 0, 1, 4'd10, 48'h1111_2222, 40'h0, 0, 0);
        expect_cnt(15, "R9 pair dropped with one slot");
        step(0, 0, 0, 0, 0, 0, 0, 1);

        // R7: accumulator truncation and mask
        step(1, 1, 0, 4'd1, 48'hFF12_3456_789A, 40'h0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        expect_acc(1'b1, 40'h12_3456_789A, "R7 acc truncate");
        step(1, 1, 0, 4'd1, 48'hEE00_0000_0001, 40'hFF_0000_0000, 1, 0);
        expect_acc(1'b1, 40'h12_0000_0001, "R7 acc mask");
        expect_acc(1'b0, 40'h0, "R7 other acc untouched");

        // R9 / R8 / R10: pair write wrapping from register 15
        step(1, 0, 1, 4'd15, 48'h0000_DEAD_BEEF, 40'hFF_FFFF_FFFF, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        expect_reg(4'd15, 16'hDEAD, "R9 pair high");
        expect_reg(4'd0, 16'hBEEF, "R9 pair low wrap");
        expect_pair(4'd15, 32'hDEAD_BEEF, "R8 pair read wrap");
        @(negedge clk); idle_in(); #1;
        chk("R10 stack pointer", 64'(sp_data), 64'(16'hDEAD));

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            bit en, a, pr, fl, dc;
            bit [39:0] k;
            en = ($urandom % 4) != 0;
            pr = ($urandom % 5) == 0;
            a  = ($urandom % 5) == 0;
            fl = ($urandom % 9) == 0;
            dc = ($urandom % 29) == 0;
            k  = ($urandom % 2) ? 40'h0 : {8'($urandom), 32'($urandom)};
            step(en, a, pr, 4'($urandom), 48'({$urandom, $urandom}), k, fl, dc);
        end

        // R11: reset in mid-run clears committed and pending state
        step(1, 0, 0, 4'd2, 48'h4242, 40'h0, 0, 0);
        do_reset();
        expect_reg(4'd15, 16'h0, "R11 reset mid-run sp");
        expect_cnt(0, "R11 reset mid-run count");
        step(0, 0, 0, 0, 0, 0, 1, 0);
        expect_reg(4'd2, 16'h0, "R11 pending cleared");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule